// File: doc/BRIEF.md
# Serial Clock-Programming Receiver

This block accepts configuration words for a clock-synthesizer register file over two pins. One pin is the serial clock and the other the serial data. Both pins are asynchronous to the system clock and share their board wiring with register-select duties, so the receiver ignores all pin activity until a distinctive preamble unlocks it. Once unlocked, it takes each payload bit twice, first inverted on a falling serial-clock edge and then true on the next rising edge. It assembles a 24-bit word and, on a load command, writes the 21-bit payload into the target register the word's 3-bit address names.

A watchdog counted in system clock cycles throws away any transfer whose pins go quiet. Malformed traffic raises a one-cycle error pulse and sends the receiver back to the locked state: a complement mismatch, a bit past the 24th, or a load aimed at an unused address. While the power-down input is high, no programming is accepted.

The write strobe, address and data of every accepted load appear at registered outputs. The synchronous target registers follow one cycle later.

Top module: `clkprog_rx`

## Requirements
- R1: After reset, the three video registers and the memory register read 0, the power-down divisor register reads 0x000008, the control register reads 0x000020, and `wr_stb_o` and `err_o` are low.
- R2: The receiver unlocks only when at least five rising serial-clock edges see data high and are followed directly by one rising edge that sees data low. A shorter run of ones leaves it locked, so the frame that follows writes nothing and raises no error.
- R3: Each bit is sampled inverted on a serial-clock falling edge and true on the next rising edge. If the two samples are equal, `err_o` pulses, nothing is written and the receiver relocks.
- R4: A word is 24 bits. The first 21 bits are the payload, least significant bit first. The last 3 bits are the address, least significant bit first.
- R5: A load command follows bit 24: data high at a falling edge, then data high at the next rising edge. It causes exactly one one-cycle pulse on `wr_stb_o`, with bit index equal to the address, and sets `wr_addr_o` and `wr_data_o` to the address and payload. The addressed register holds the payload from the next cycle on, and the receiver relocks.
- R6: Address 0, 1 and 2 select the video registers, 3 the memory register, 4 the power-down divisor and 6 the control register. A load to address 5 or 7 pulses `err_o`, raises no strobe and changes no register.
- R7: After bit 24, any traffic other than a load command pulses `err_o` once, writes nothing and relocks.
- R8: Once the receiver has left its idle locked state, WD_CYCLES system cycles with no edge on either synchronized pin discard the partial word and preamble count without an error. Later traffic without a new preamble writes nothing, and a fresh unlocked frame is accepted normally.
- R9: While `pwr_down_i` is high, the receiver stays locked: a complete frame writes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down_i | input | 1 | Power-down active; programming refused |
| ser_ck_i | input | 1 | Serial clock pin, asynchronous |
| ser_dt_i | input | 1 | Serial data pin, asynchronous |
| wr_stb_o | output | 8 | One-cycle write strobe, one bit per address code |
| wr_addr_o | output | 3 | Address of the last load |
| wr_data_o | output | 21 | Payload of the last load |
| err_o | output | 1 | One-cycle protocol error pulse |
| vid0_o | output | 21 | Video register 0 contents |
| vid1_o | output | 21 | Video register 1 contents |
| vid2_o | output | 21 | Video register 2 contents |
| mem_o | output | 21 | Memory clock register contents |
| pdiv_o | output | 21 | Power-down divisor register contents |
| ctrl_o | output | 21 | Control register contents |

## Verification
The assertions check the following on every cycle: the strobe is at most one-hot and never shares a cycle with an error, power-down blocks the next strobe and holds the receiver locked, a watchdog expiry always lands in a cleared locked state, the bit counter stays within the word, and a strobed register takes the strobed data. Other behaviour depends on whole pin sequences, so only the bench scenarios can show it. That covers the five-ones threshold of the preamble, the bit order of payload and address, complement and overflow errors, the silent discard after a stall, and traffic after a relock that writes nothing.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;
  localparam int PAY_W  = 21;
  localparam int ADR_W  = 3;
  localparam int N_ADR  = 1 << ADR_W;
  localparam logic [N_ADR-1:0] ADR_VALID = 8'b0101_1111;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_FULL   = 2'd2
  } rx_state_e;

  function automatic logic [PAY_W-1:0] reset_value(input int adr);
    case (adr)
      4:       reset_value = PAY_W'(8);
      6:       reset_value = PAY_W'(32);
      default: reset_value = '0;
    endcase
  endfunction
endpackage

// File: rtl/cp_pin_sync.sv
module cp_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
      prev_q <= '1;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_edge
      assign lvl_o[g]  = stage_q[STAGES-1][g];
      assign rise_o[g] = stage_q[STAGES-1][g] & ~prev_q[g];
      assign fall_o[g] = ~stage_q[STAGES-1][g] & prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/cp_watchdog.sv
module cp_watchdog #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || kick_i || !active_i) cnt_q <= '0;
    else if (cnt_q != LIM)           cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = active_i && (cnt_q == LIM);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM) else $error("watchdog count past limit"); // R8
endmodule

// File: rtl/cp_frame_fsm.sv
module cp_frame_fsm
  import clkprog_pkg::*;
#(
  parameter int DATA_W  = PAY_W,
  parameter int ADDR_W  = ADR_W,
  parameter int PRE_MIN = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pd_i,
  input  logic                     wd_exp_i,
  input  logic                     ck_rise_i,
  input  logic                     ck_fall_i,
  input  logic                     dt_i,
  output logic                     active_o,
  output logic                     ld_fire_o,
  output logic                     err_fire_o,
  output logic [DATA_W+ADDR_W-1:0] word_o
);
  localparam int WORD_W = DATA_W + ADDR_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PRE_W  = $clog2(PRE_MIN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [PRE_W-1:0] PRE_SAT  = PRE_W'(PRE_MIN);

  rx_state_e         state_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sreg_q;
  logic              comp_q;
  logic              fall_seen_q;
  logic              blocked;
  logic              shift_bad;
  logic              full_bad;

  assign blocked    = pd_i || wd_exp_i;
  assign shift_bad  = (state_q == ST_SHIFT) && ck_rise_i && (!fall_seen_q || comp_q == dt_i);
  assign full_bad   = (state_q == ST_FULL) &&
                      ((ck_fall_i && !dt_i) || (ck_rise_i && !(fall_seen_q && dt_i)));
  assign err_fire_o = !blocked && (shift_bad || full_bad);
  assign ld_fire_o  = !blocked && (state_q == ST_FULL) && ck_rise_i && fall_seen_q && dt_i;
  assign active_o   = (state_q != ST_LOCKED) || (pre_q != '0);
  assign word_o     = sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOCKED;
      pre_q       <= '0;
      bit_q       <= '0;
      sreg_q      <= '0;
      comp_q      <= 1'b0;
      fall_seen_q <= 1'b0;
    end else if (blocked || err_fire_o || ld_fire_o) begin
      state_q     <= ST_LOCKED;
      pre_q       <= '0;
      fall_seen_q <= 1'b0;
    end else begin
      case (state_q)
        ST_LOCKED: begin
          if (ck_rise_i) begin
            if (dt_i) begin
              if (pre_q != PRE_SAT) pre_q <= pre_q + 1'b1;
            end else if (pre_q == PRE_SAT) begin
              state_q     <= ST_SHIFT;
              bit_q       <= '0;
              fall_seen_q <= 1'b0;
              pre_q       <= '0;
            end else begin
              pre_q <= '0;
            end
          end
        end
        ST_SHIFT: begin
          if (ck_fall_i) begin
            comp_q      <= dt_i;
            fall_seen_q <= 1'b1;
          end else if (ck_rise_i) begin
            sreg_q      <= {dt_i, sreg_q[WORD_W-1:1]};
            bit_q       <= bit_q + 1'b1;
            fall_seen_q <= 1'b0;
            if (bit_q == LAST_BIT) state_q <= ST_FULL;
          end
        end
        ST_FULL: begin
          if (ck_fall_i) fall_seen_q <= 1'b1;
        end
        default: state_q <= ST_LOCKED;
      endcase
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_q <= CNT_W'(WORD_W)) else $error("bit counter beyond word"); // R4
  AST_TIMEOUT_RELOCK: assert property (@(posedge clk) disable iff (rst)
    wd_exp_i |=> (state_q == ST_LOCKED) && (pre_q == '0)) else $error("no relock on timeout"); // R8
  AST_PD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> state_q == ST_LOCKED) else $error("unlocked during power-down"); // R9
endmodule

// File: rtl/cp_target_regs.sv
module cp_target_regs
  import clkprog_pkg::*;
#(
  parameter int DATA_W = PAY_W,
  parameter int NADR   = N_ADR,
  parameter logic [NADR-1:0] VALID = ADR_VALID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NADR-1:0]   we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] regs_o [NADR]
);
  genvar k;
  generate
    for (k = 0; k < NADR; k++) begin : g_reg
      if (VALID[k]) begin : g_live
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk) begin
          if (rst)        r_q <= DATA_W'(reset_value(k));
          else if (we_i[k]) r_q <= wdata_i;
        end
        assign regs_o[k] = r_q;

        AST_REG_UPDATE: assert property (@(posedge clk) disable iff (rst)
          we_i[k] |=> r_q == $past(wdata_i)) else $error("register missed write"); // R5
      end else begin : g_hole
        assign regs_o[k] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/clkprog_rx.sv
module clkprog_rx
  import clkprog_pkg::*;
#(
  parameter int WD_CYCLES = 500000,
  parameter int PRE_MIN   = 5,
  parameter int SYNC_FF   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_down_i,
  input  logic             ser_ck_i,
  input  logic             ser_dt_i,
  output logic [N_ADR-1:0] wr_stb_o,
  output logic [ADR_W-1:0] wr_addr_o,
  output logic [PAY_W-1:0] wr_data_o,
  output logic             err_o,
  output logic [PAY_W-1:0] vid0_o,
  output logic [PAY_W-1:0] vid1_o,
  output logic [PAY_W-1:0] vid2_o,
  output logic [PAY_W-1:0] mem_o,
  output logic [PAY_W-1:0] pdiv_o,
  output logic [PAY_W-1:0] ctrl_o
);
  localparam int WORD_W = PAY_W + ADR_W;

  logic [1:0]        lvl, rise, fall;
  logic              active, wd_exp, ld_fire, err_fire;
  logic [WORD_W-1:0] word;
  logic [ADR_W-1:0]  ld_adr;
  logic              adr_ok;
  logic [N_ADR-1:0]  dec;
  logic [PAY_W-1:0]  regs [N_ADR];

  cp_pin_sync #(.WIDTH(2), .STAGES(SYNC_FF)) i_sync (
    .clk(clk), .rst(rst), .pin_i({ser_dt_i, ser_ck_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  cp_watchdog #(.LIMIT(WD_CYCLES)) i_wd (
    .clk(clk), .rst(rst), .active_i(active),
    .kick_i(|(rise | fall)), .expire_o(wd_exp)
  );

  cp_frame_fsm #(.DATA_W(PAY_W), .ADDR_W(ADR_W), .PRE_MIN(PRE_MIN)) i_fsm (
    .clk(clk), .rst(rst), .pd_i(pwr_down_i), .wd_exp_i(wd_exp),
    .ck_rise_i(rise[0]), .ck_fall_i(fall[0]), .dt_i(lvl[1]),
    .active_o(active), .ld_fire_o(ld_fire), .err_fire_o(err_fire), .word_o(word)
  );

  assign ld_adr = word[WORD_W-1 -: ADR_W];
  assign adr_ok = ADR_VALID[ld_adr];

  genvar g;
  generate
    for (g = 0; g < N_ADR; g++) begin : g_dec
      assign dec[g] = ADR_VALID[g] && (ld_adr == ADR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o  <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      wr_stb_o <= ld_fire ? dec : '0;
      err_o    <= err_fire || (ld_fire && !adr_ok);
      if (ld_fire) begin
        wr_addr_o <= ld_adr;
        wr_data_o <= word[PAY_W-1:0];
      end
    end
  end

  cp_target_regs #(.DATA_W(PAY_W), .NADR(N_ADR), .VALID(ADR_VALID)) i_regs (
    .clk(clk), .rst(rst), .we_i(wr_stb_o), .wdata_i(wr_data_o), .regs_o(regs)
  );

  assign vid0_o = regs[0];
  assign vid1_o = regs[1];
  assign vid2_o = regs[2];
  assign mem_o  = regs[3];
  assign pdiv_o = regs[4];
  assign ctrl_o = regs[6];

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb_o)) else $error("strobe not one-hot"); // R5
  AST_ERR_NO_STB: assert property (@(posedge clk) disable iff (rst)
    !(err_o && (wr_stb_o != '0))) else $error("error with strobe"); // R6
  AST_PD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> wr_stb_o == '0) else $error("write during power-down"); // R9
endmodule

// File: tb/test_clkprog_rx.sv
module test_clkprog_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pd = 1'b0;
  logic        ck = 1'b1;
  logic        dt = 1'b1;
  logic [7:0]  wr_stb;
  logic [2:0]  wr_addr;
  logic [20:0] wr_data;
  logic        err;
  logic [20:0] vid0, vid1, vid2, memr, pdiv, ctrl;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  int err_cnt = 0;
  logic [7:0] last_stb = '0;
  bit done = 0;

  localparam int HOLD = 4;

  always #2 clk = ~clk;

  clkprog_rx #(.WD_CYCLES(64)) i_clkprog_rx (
    .clk(clk), .rst(rst), .pwr_down_i(pd), .ser_ck_i(ck), .ser_dt_i(dt),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .err_o(err),
    .vid0_o(vid0), .vid1_o(vid1), .vid2_o(vid2), .mem_o(memr),
    .pdiv_o(pdiv), .ctrl_o(ctrl)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb != '0) begin stb_cnt++; last_stb = wr_stb; end
      if (err) err_cnt++;
    end
  end

  // {expect_err, addr, payload}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 3'd0, 21'h012345},
    {1'b0, 3'd1, 21'h1F00F1},
    {1'b0, 3'd2, 21'h000001},
    {1'b0, 3'd3, 21'h155555},
    {1'b0, 3'd4, 21'h00000C},
    {1'b0, 3'd6, 21'h0AAAAA},
    {1'b1, 3'd5, 21'h033333},
    {1'b1, 3'd7, 21'h1FFFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [20:0] reg_of(input logic [2:0] a);
    case (a)
      3'd0: reg_of = vid0;
      3'd1: reg_of = vid1;
      3'd2: reg_of = vid2;
      3'd3: reg_of = memr;
      3'd4: reg_of = pdiv;
      3'd6: reg_of = ctrl;
      default: reg_of = '0;
    endcase
  endfunction

  task automatic ck_pulse(input logic dfall, input logic drise);
    dt = dfall; idle(HOLD);
    ck = 1'b0;  idle(HOLD);
    dt = drise; idle(HOLD);
    ck = 1'b1;  idle(HOLD);
  endtask

  task automatic send_bit(input logic b);
    ck_pulse(~b, b);
  endtask

  task automatic send_pre(input int n);
    for (int i = 0; i < n; i++) ck_pulse(1'b1, 1'b1);
    ck_pulse(1'b1, 1'b0);
  endtask

  task automatic send_body(input logic [2:0] a, input logic [20:0] d);
    for (int i = 0; i < 21; i++) send_bit(d[i]);
    for (int i = 0; i < 3; i++) send_bit(a[i]);
  endtask

  task automatic send_load();
    ck_pulse(1'b1, 1'b1);
  endtask

  task automatic frame(input int npre, input logic [2:0] a, input logic [20:0] d);
    send_pre(npre);
    send_body(a, d);
    send_load();
    idle(10);
  endtask

  initial begin
    int s0, e0;
    logic [20:0] keep;
    rst = 1'b1;
    idle(6);
    @(negedge clk) rst = 1'b0;
    idle(4);
    @(negedge clk);
    // R1 reset state
    chk(vid0 == 0 && vid1 == 0 && vid2 == 0, "R1 video regs", {11'd0, vid0 | vid1 | vid2}, 0);
    chk(memr == 0, "R1 mem reg", memr, 0);
    chk(pdiv == 21'h8, "R1 pdiv reg", pdiv, 21'h8);
    chk(ctrl == 21'h20, "R1 ctrl reg", ctrl, 21'h20);
    chk(wr_stb == 0 && err == 0, "R1 strobe/err", {wr_stb, 7'd0, err}, 0);

    // R4 R5 R6 vector walk
    for (int v = 0; v < 8; v++) begin
      logic        xe;
      logic [2:0]  xa;
      logic [20:0] xd;
      {xe, xa, xd} = VEC[v];
      s0 = stb_cnt; e0 = err_cnt;
      frame(5, xa, xd);
      @(negedge clk);
      if (!xe) begin
        chk(stb_cnt == s0 + 1, "R5 one strobe", stb_cnt - s0, 1);
        chk(last_stb == (8'd1 << xa), "R5 strobe index", last_stb, 8'd1 << xa);
        chk(wr_addr == xa && wr_data == xd, "R4 addr/data order", {8'd0, wr_addr, wr_data}, {8'd0, xa, xd});
        chk(reg_of(xa) == xd, "R6 target reg", reg_of(xa), xd);
        chk(err_cnt == e0, "R5 no error", err_cnt - e0, 0);
      end else begin
        chk(stb_cnt == s0, "R6 unused addr no strobe", stb_cnt - s0, 0);
        chk(err_cnt == e0 + 1, "R6 unused addr error", err_cnt - e0, 1);
      end
    end
    chk(vid0 == 21'h012345 && ctrl == 21'h0AAAAA, "R6 other regs kept", vid0, 21'h012345);

    // R2 longer preamble accepted
    frame(9, 3'd2, 21'h0F0F0F);
    @(negedge clk);
    chk(vid2 == 21'h0F0F0F, "R2 long preamble", vid2, 21'h0F0F0F);

    // R2 four ones: stays locked
    idle(100);
    s0 = stb_cnt; e0 = err_cnt;
    frame(4, 3'd0, 21'h0);
    idle(100);
    @(negedge clk);
    chk(stb_cnt == s0 && vid0 == 21'h012345, "R2 short preamble no write", vid0, 21'h012345);
    chk(err_cnt == e0, "R2 short preamble no error", err_cnt - e0, 0);

    // R3 complement mismatch
    idle(100);
    s0 = stb_cnt; e0 = err_cnt;
    send_pre(5);
    send_bit(1'b1);
    ck_pulse(1'b1, 1'b1);
    idle(10);
    @(negedge clk);
    chk(err_cnt == e0 + 1, "R3 mismatch error", err_cnt - e0, 1);
    chk(stb_cnt == s0, "R3 mismatch no write", stb_cnt - s0, 0);

    // R7 extra bit after full word
    idle(100);
    s0 = stb_cnt; e0 = err_cnt;
    send_pre(5);
    send_body(3'd3, 21'h000777);
    send_bit(1'b0);
    send_load();
    idle(10);
    @(negedge clk);
    chk(err_cnt == e0 + 1, "R7 overflow error", err_cnt - e0, 1);
    chk(stb_cnt == s0 && memr == 21'h155555, "R7 overflow no write", memr, 21'h155555);

    // R8 stall mid-frame, then remainder without preamble
    idle(100);
    s0 = stb_cnt; e0 = err_cnt;
    send_pre(5);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    idle(200);
    for (int i = 0; i < 14; i++) send_bit(1'b0);
    send_load();
    idle(100);
    @(negedge clk);
    chk(stb_cnt == s0 && err_cnt == e0, "R8 stalled frame discarded", stb_cnt - s0 + err_cnt - e0, 0);
    chk(vid0 == 21'h012345, "R8 reg untouched", vid0, 21'h012345);
    frame(5, 3'd1, 21'h1ABCDE);
    @(negedge clk);
    chk(vid1 == 21'h1ABCDE && stb_cnt == s0 + 1, "R8 fresh frame after stall", vid1, 21'h1ABCDE);

    // R9 power-down refuses programming
    idle(100);
    keep = vid2;
    s0 = stb_cnt; e0 = err_cnt;
    pd = 1'b1;
    frame(5, 3'd2, 21'h111111);
    pd = 1'b0;
    idle(100);
    @(negedge clk);
    chk(vid2 == keep && stb_cnt == s0, "R9 no write in power-down", vid2, keep);
    chk(err_cnt == e0, "R9 no error in power-down", err_cnt - e0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule